// File: doc/BRIEF.md
# Hold-Off Ramp Sequencer

This block sits in one channel of a transmit path and decides when a time-slot power envelope is shaped. A sync pulse, already chosen by routing logic outside the block, loads a hold-off counter with a programmed start count. The counter then steps down once per clock. When it reaches one, the block starts stepping the address of an external coefficient memory that feeds the envelope multiplier.

The envelope runs in three phases. A falling ramp walks the address from the last coefficient of the programmed length down to the first. An optional rest follows, holding the first coefficient for a programmed number of cycles. A rising ramp then walks from the first coefficient back up to the last. A sync that arrives at any point reloads the counter and restarts the countdown, so holding sync high only postpones the envelope.

Top module: `holdoff_ramp_seq`

## Requirements
- R1: After reset, active_o and rest_o are 0 and addr_o is 0.
- R2: A clock edge that samples sync_i high loads the counter with hold_cnt_i. The first falling-ramp cycle appears on the outputs exactly max(hold_cnt_i,1) clock edges after the last such load edge, because the countdown triggers when the counter holds one. A start count of 0 behaves as 1.
- R3: While sync_i stays high, the counter is reloaded on every edge and active_o stays 0. The countdown runs only after sync_i returns low.
- R4: A sync_i high for a single clock period is captured and starts a countdown.
- R5: During the falling ramp, active_o is 1, rest_o is 0, and addr_o takes the values L-1, L-2, ..., 0, one per clock, where L is the effective ramp length.
- R6: When rest_len_i is nonzero, the falling ramp is followed by exactly rest_len_i cycles with rest_o=1, active_o=1 and addr_o=0.
- R7: When rest_len_i is zero, the rising ramp begins on the clock right after addr_o=0 of the falling ramp, and rest_o never rises.
- R8: During the rising ramp, addr_o takes 0, 1, ..., L-1, one per clock, with active_o=1. On the next clock active_o drops to 0 and addr_o holds L-1.
- R9: The effective length L is ramp_len_i clamped to the range 1..64 for the default 6-bit address: 0 acts as 1, and values above 64 act as 64.
- R10: A sync_i sampled high during a falling ramp, rest or rising ramp aborts the envelope. On the next clock active_o and rest_o are 0 and a fresh countdown from hold_cnt_i is under way.
- R11: rest_o is never 1 while active_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Selected sync pulse, active high |
| hold_cnt_i | input | CNT_W (16) | Hold-off start count |
| ramp_len_i | input | ADDR_W+1 (7) | Programmed ramp length in coefficients |
| rest_len_i | input | REST_W (8) | Rest length in cycles, 0 for none |
| addr_o | output | ADDR_W (6) | Coefficient memory address |
| active_o | output | 1 | Envelope in progress |
| rest_o | output | 1 | Rest phase in progress |

## Verification
The bench builds the block with its default parameters: a 16-bit hold-off counter, a 6-bit address and an 8-bit rest length. The 7-bit length input can then carry both a full 64-coefficient ramp and an out-of-range value of 100, so both ends of the clamp can be reached. Short start counts of 0, 1, 2 and 5 keep the countdown boundary in view without long idle waits. Aborts are placed both in a falling ramp and inside a rest.

// File: rtl/holdoff_ramp_seq.sv
module holdoff_ramp_seq #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6,
  parameter int REST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [CNT_W-1:0]  hold_cnt_i,
  input  logic [ADDR_W:0]   ramp_len_i,
  input  logic [REST_W-1:0] rest_len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              active_o,
  output logic              rest_o
);
  localparam int LEN_W   = ADDR_W + 1;
  localparam int MAX_LEN = 1 << ADDR_W;

  typedef enum logic [2:0] {S_IDLE, S_COUNT, S_DOWN, S_REST, S_UP} state_t;

  state_t            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REST_W-1:0] rest_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_eff;
  logic [LEN_W-1:0]  last_w;
  logic              at_last;

  assign len_eff = (ramp_len_i == '0) ? LEN_W'(1) :
                   (ramp_len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : ramp_len_i;
  assign last_w  = len_eff - LEN_W'(1);
  assign at_last = ({1'b0, addr_q} == last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      rest_q  <= '0;
      addr_q  <= '0;
    end else if (sync_i) begin
      state_q <= S_COUNT;
      cnt_q   <= hold_cnt_i;
    end else begin
      case (state_q)
        S_COUNT: begin
          if (cnt_q <= CNT_W'(1)) begin
            state_q <= S_DOWN;
            addr_q  <= last_w[ADDR_W-1:0];
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        S_DOWN: begin
          if (addr_q == '0) begin
            if (rest_len_i == '0) begin
              state_q <= S_UP;
            end else begin
              state_q <= S_REST;
              rest_q  <= rest_len_i;
            end
          end else begin
            addr_q <= addr_q - ADDR_W'(1);
          end
        end
        S_REST: begin
          if (rest_q <= REST_W'(1)) state_q <= S_UP;
          else rest_q <= rest_q - REST_W'(1);
        end
        S_UP: begin
          if (at_last) state_q <= S_IDLE;
          else addr_q <= addr_q + ADDR_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign addr_o   = addr_q;
  assign active_o = (state_q == S_DOWN) || (state_q == S_REST) || (state_q == S_UP);
  assign rest_o   = (state_q == S_REST);

  p_trigger_at_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> ($past(state_q) == S_COUNT) && ($past(cnt_q) <= CNT_W'(1)));

  p_sync_aborts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !active_o && !rest_o);

  p_down_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DOWN && addr_q != '0 && !sync_i) |=> (addr_o == $past(addr_o) - ADDR_W'(1)) && active_o);

  p_rest_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rest_o |-> addr_o == '0);

  p_up_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_UP && !at_last && !sync_i) |=> addr_o == $past(addr_o) + ADDR_W'(1));

  p_up_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_UP && at_last && !sync_i) |=> !active_o && $stable(addr_o));

  p_rest_in_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rest_o |-> active_o);
endmodule

// File: tb/holdoff_ramp_seq_tb_top.sv
module holdoff_ramp_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic [15:0] hold_cnt_i = '0;
  logic [6:0]  ramp_len_i = 7'd1;
  logic [7:0]  rest_len_i = '0;
  logic [5:0]  addr_o;
  logic        active_o;
  logic        rest_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  holdoff_ramp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .hold_cnt_i(hold_cnt_i),
    .ramp_len_i(ramp_len_i), .rest_len_i(rest_len_i),
    .addr_o(addr_o), .active_o(active_o), .rest_o(rest_o));

  function automatic int obs();
    return {24'd0, active_o, rest_o, addr_o};
  endfunction

  function automatic int pack(input int a, input int r, input int ad);
    return (a << 7) | (r << 6) | ad;
  endfunction

  function automatic int clamp_len(input int l);
    if (l == 0) return 1;
    if (l > 64) return 64;
    return l;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input string tag, input int n, input int l, input int r,
                         input int hold, input int stop);
    int le = clamp_len(l);
    int ne = (n == 0) ? 1 : n;
    int seen = 0;
    hold_cnt_i = 16'(n);
    ramp_len_i = 7'(l);
    rest_len_i = 8'(r);
    sync_i = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk($sformatf("%s R3/R10 idle while sync high", tag), obs() >> 6, 0);
    end
    sync_i = 1'b0;
    for (int k = 1; k < ne; k++) begin
      @(negedge clk);
      chk($sformatf("%s R2 countdown k=%0d", tag, k), obs() >> 6, 0);
    end
    for (int i = 0; i < le; i++) begin
      @(negedge clk);
      chk($sformatf("%s R5 down i=%0d", tag, i), obs(), pack(1, 0, le - 1 - i));
      seen++;
      if (stop >= 0 && seen >= stop) return;
    end
    for (int i = 0; i < r; i++) begin
      @(negedge clk);
      chk($sformatf("%s R6 rest i=%0d", tag, i), obs(), pack(1, 1, 0));
      seen++;
      if (stop >= 0 && seen >= stop) return;
    end
    for (int i = 0; i < le; i++) begin
      @(negedge clk);
      chk($sformatf("%s %s up i=%0d", tag, (r == 0 && i == 0) ? "R7" : "R8", i),
          obs(), pack(1, 0, i));
    end
    @(negedge clk);
    chk($sformatf("%s R8 end", tag), obs(), pack(0, 0, le - 1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset state", obs(), pack(0, 0, 0));
  endtask

  task automatic t_basic();    run_seq("basic",   5, 4, 3, 1, -1); endtask
  task automatic t_minimal();  run_seq("R4 pulse", 1, 1, 0, 1, -1); endtask
  task automatic t_zero_cnt(); run_seq("R2 zero",  0, 3, 0, 1, -1); endtask
  task automatic t_held();     run_seq("R3 held",  2, 2, 2, 6, -1); endtask
  task automatic t_full();     run_seq("R9 full",  2, 64, 1, 1, -1); endtask
  task automatic t_clamp_lo(); run_seq("R9 lo",    3, 0, 2, 1, -1); endtask
  task automatic t_clamp_hi(); run_seq("R9 hi",    1, 100, 0, 1, -1); endtask

  task automatic t_abort_down();
    run_seq("R10 pre-down", 4, 6, 2, 1, 3);
    run_seq("R10 after-down", 3, 2, 1, 1, -1);
  endtask

  task automatic t_abort_rest();
    run_seq("R10 pre-rest", 2, 2, 5, 1, 4);
    chk("R11 rest within active", obs(), pack(1, 1, 0));
    run_seq("R10 after-rest", 2, 3, 0, 1, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_minimal();
    t_zero_cnt();
    t_held();
    t_full();
    t_clamp_lo();
    t_clamp_hi();
    t_abort_down();
    t_abort_rest();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule